// File: doc/BRIEF.md
# Multi-pin transition count compactor

This block condenses the responses of a device under test into one small number per observed output pin, for go/no-go screening. Each pin has its own counter, which goes up by one whenever the sampled level of that pin differs from its level at the previous sample. A change from low to high counts, and so does a change from high to low. Over a whole test run the block therefore keeps NUM_PINS counts instead of the full response stream.

When the run ends, the test controller pulses `done_i`. The block then compares every pin's count with a reference count presented on `ref_i`. The reference counts are obtained by running the same pattern sequence on a device known to be good. The block registers a per-pin mismatch vector and a single combined fail bit, and it holds both until the next clear.

The counter width follows from the longest run that is expected. `MAX_SAMPLES` samples per pin need ceil(log2 MAX_SAMPLES) bits, so a run of 2^24 patterns gives 24-bit counters. A counter saturates rather than wrapping, so an overflowing count still shows up as a mismatch. Faults that leave the number of transitions unchanged cannot be detected, so the order of the patterns determines how well the test covers faults.

Top module: `tcc_compactor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `fail_o` is 0 and `mismatch_o` is all zeros.
- R2: Each pin p (bit p of `resp_i`) has its own counter. Activity on one pin never changes the count of another pin.
- R3: On a sample (`sample_i` high), if pin p differs from its previously sampled level, its count goes up by one. This holds for both a 0-to-1 change and a 1-to-0 change.
- R4: The first sample after reset or clear only records the level of each pin. It never adds to a count.
- R5: The eight-sample stream 1,0,1,0,1,0,1,0 on one pin gives a count of 7.
- R6: A count stops at 2^CNT_W-1, where CNT_W = ceil(log2 MAX_SAMPLES). Further transitions leave it there, and it never wraps to a smaller value.
- R7: `mismatch_o` and `fail_o` take their new values at the clock edge where `done_i` is sampled high, so they are visible one cycle after `done_i`. After that they stay constant until the next `clear_i` or `done_i`.
- R8: Bit p of `mismatch_o` is 1 exactly when pin p's count differs from reference field p, which is `ref_i[p*CNT_W +: CNT_W]`. `fail_o` is the OR of all mismatch bits.
- R9: `clear_i` zeroes all counts, forgets every previous level, and drops `mismatch_o` and `fail_o` to 0. If `sample_i` is high in the same cycle, `clear_i` wins and the sample is discarded.
- R10: While `sample_i` is low, changes on `resp_i` have no effect on any count.
- R11: `ref_i` is read only in the `done_i` cycle. Changing it at any other time leaves the verdict unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Start of run: zeroes counts and verdict |
| sample_i | input | 1 | Strobe: take `resp_i` this cycle |
| resp_i | input | NUM_PINS | Parallel response bus from the device under test |
| ref_i | input | NUM_PINS*CNT_W | Reference counts, field p for pin p |
| done_i | input | 1 | End of run: compare the counts with the references |
| mismatch_o | output | NUM_PINS | Registered per-pin mismatch flags |
| fail_o | output | 1 | Registered combined fail result |

## Verification
A wrong previous-level bit or a wrong first-sample flag changes a count by one. The error stays hidden inside the block until `done_i`, and then shows as a single mismatch bit one cycle later, on the pin it belongs to. A counter that wraps, or that leaks into a neighbouring pin, shows the same way at the end of the run. For that reason the stimulus uses streams whose counts are known exactly: an alternating stream, constant streams, single edges, a run long enough to saturate, and a clear issued in the same cycle as a sample. The verdict registers themselves are watched directly. They are checked for holding their value while `ref_i` changes, and for clearing one cycle after `clear_i`.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  // counter width for a run of m samples: at most m-1 transitions
  function automatic int cnt_width(int m);
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/tcc_pin_counter.sv
module tcc_pin_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic prev_q;
  logic primed_q;
  logic edge_seen;

  assign edge_seen = primed_q && (bit_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
      count_o  <= '0;
    end else if (sample_i) begin
      prev_q   <= bit_i;
      primed_q <= 1'b1;
      if (edge_seen && (count_o != CNT_MAX))
        count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/tcc_verdict.sv
module tcc_verdict #(
  parameter int NUM_PINS = 4,
  parameter int CNT_W    = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear_i,
  input  logic                      done_i,
  input  logic [NUM_PINS*CNT_W-1:0] count_i,
  input  logic [NUM_PINS*CNT_W-1:0] ref_i,
  output logic [NUM_PINS-1:0]       mismatch_o,
  output logic                      fail_o
);
  logic [NUM_PINS-1:0] diff;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign diff[g] = (count_i[g*CNT_W +: CNT_W] != ref_i[g*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      mismatch_o <= '0;
      fail_o     <= 1'b0;
    end else if (done_i) begin
      mismatch_o <= diff;
      fail_o     <= |diff;
    end
  end
endmodule

// File: rtl/tcc_compactor.sv
module tcc_compactor #(
  parameter int NUM_PINS    = 4,
  parameter int MAX_SAMPLES = 16777216,
  localparam int CNT_W      = tcc_pkg::cnt_width(MAX_SAMPLES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear_i,
  input  logic                      sample_i,
  input  logic [NUM_PINS-1:0]       resp_i,
  input  logic [NUM_PINS*CNT_W-1:0] ref_i,
  input  logic                      done_i,
  output logic [NUM_PINS-1:0]       mismatch_o,
  output logic                      fail_o
);
  logic [NUM_PINS*CNT_W-1:0] cnt_flat;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    tcc_pin_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clear_i (clear_i),
      .sample_i(sample_i),
      .bit_i   (resp_i[p]),
      .count_o (cnt_flat[p*CNT_W +: CNT_W])
    );
  end

  tcc_verdict #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_i),
    .done_i    (done_i),
    .count_i   (cnt_flat),
    .ref_i     (ref_i),
    .mismatch_o(mismatch_o),
    .fail_o    (fail_o)
  );
endmodule

// File: rtl/tcc_compactor_chk.sv
module tcc_compactor_chk #(
  parameter int NUM_PINS = 4,
  parameter int CNT_W    = 24
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      clear_i,
  input logic                      sample_i,
  input logic                      done_i,
  input logic [NUM_PINS*CNT_W-1:0] cnt_flat,
  input logic [NUM_PINS-1:0]       mismatch_o,
  input logic                      fail_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!fail_o && (mismatch_o == '0)));

  p_fail_is_or_r8: assert property (@(posedge clk) disable iff (rst)
    fail_o == (|mismatch_o));

  p_verdict_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!done_i && !clear_i) |=> ($stable(fail_o) && $stable(mismatch_o)));

  p_clear_wipes_r9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!fail_o && (mismatch_o == '0) && (cnt_flat == '0)));

  p_idle_no_count_r10: assert property (@(posedge clk) disable iff (rst)
    (!sample_i && !clear_i) |=> $stable(cnt_flat));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      !clear_i |=> (cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W])));
    p_sat_stays_r6: assert property (@(posedge clk) disable iff (rst)
      ((cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX) && !clear_i)
        |=> (cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX));
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
      !clear_i |=> ((cnt_flat[g*CNT_W +: CNT_W] - $past(cnt_flat[g*CNT_W +: CNT_W])) <= 1));
  end
endmodule

bind tcc_compactor tcc_compactor_chk #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear_i   (clear_i),
  .sample_i  (sample_i),
  .done_i    (done_i),
  .cnt_flat  (cnt_flat),
  .mismatch_o(mismatch_o),
  .fail_o    (fail_o)
);

// File: tb/tcc_compactor_test.sv
module tcc_compactor_test;
  localparam int K  = 4;
  localparam int MS = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear_i = 1'b0;
  logic          sample_i = 1'b0;
  logic [K-1:0]  resp_i = '0;
  logic [K*CW-1:0] ref_i = '0;
  logic          done_i = 1'b0;
  logic [K-1:0]  mismatch_o;
  logic          fail_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tcc_compactor #(.NUM_PINS(K), .MAX_SAMPLES(MS)) uut (
    .clk(clk), .rst(rst), .clear_i(clear_i), .sample_i(sample_i),
    .resp_i(resp_i), .ref_i(ref_i), .done_i(done_i),
    .mismatch_o(mismatch_o), .fail_o(fail_o)
  );

  // [47:16] four 8-sample streams (pin p in byte p, sample s = bit s), [15:0] refs
  localparam logic [47:0] VECS [4] = '{
    {32'h0F_FF_00_AA, 16'h1007},
    {32'h0F_FF_00_AA, 16'h2007},
    {32'h81_F0_33_55, 16'h2137},
    {32'h80_04_02_01, 16'h0000}
  };

  function automatic int tc8(logic [7:0] s);
    int c = 0;
    for (int i = 0; i < 7; i++) if (s[i] != s[i+1]) c++;
    return c;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  task automatic do_sample(logic [K-1:0] v);
    @(negedge clk); sample_i = 1'b1; resp_i = v;
    @(negedge clk); sample_i = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fail in reset", fail_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mismatch after reset", mismatch_o, 0);

    // table: R2 R3 R4 R5 R8
    for (int e = 0; e < 4; e++) begin
      logic [3:0] expm;
      do_clear();
      for (int s = 0; s < 8; s++) begin
        logic [K-1:0] v;
        for (int p = 0; p < K; p++) v[p] = VECS[e][16 + p*8 + s];
        do_sample(v);
      end
      ref_i = VECS[e][15:0];
      expm = '0;
      for (int p = 0; p < K; p++)
        expm[p] = (tc8(VECS[e][16+p*8 +: 8]) != int'(VECS[e][p*4 +: 4]));
      check("R8 R3 R5 mismatch vector", mismatch_o, 0);
      do_done();
      check("R2 R4 R8 mismatch vector", mismatch_o, expm);
      check("R8 fail bit", fail_o, (expm != 0) ? 1 : 0);
    end

    // R7 R11: verdict held while ref_i changes
    ref_i = '0;
    repeat (3) @(negedge clk);
    check("R11 verdict held", mismatch_o, 4'hF);
    check("R7 fail held", fail_o, 1);

    // R9: clear wipes verdict and counts
    do_clear();
    check("R9 verdict cleared", fail_o, 0);
    ref_i = '0;
    do_done();
    check("R9 counts cleared", mismatch_o, 0);

    // R10: resp changes without strobe are ignored
    do_clear();
    do_sample(4'h0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); resp_i = (i % 2 == 0) ? 4'hF : 4'h0;
    end
    ref_i = '0;
    do_done();
    check("R10 unstrobed ignored", mismatch_o, 0);

    // R9 clear priority over sample: expect pin0 count 1
    @(negedge clk); clear_i = 1'b1; sample_i = 1'b1; resp_i = 4'h0;
    @(negedge clk); clear_i = 1'b0; sample_i = 1'b0;
    do_sample(4'h1);
    do_sample(4'h0);
    ref_i = 16'h0001;
    do_done();
    check("R9 clear beats sample", mismatch_o, 0);

    // R6 saturation: 20 alternating samples on pin0 -> 19 transitions, cap 15
    do_clear();
    for (int i = 0; i < 20; i++) do_sample((i % 2 == 0) ? 4'h1 : 4'h0);
    ref_i = 16'h000F;
    do_done();
    check("R6 saturated at max", mismatch_o, 0);
    ref_i = 16'h0003;
    do_done();
    check("R6 no wrap", mismatch_o, 1);
    check("R7 recompute on done", fail_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule